// File: doc/BRIEF.md
# Escape-Extended Length Decoder

This block sits on a byte stream with a valid/ready handshake and splits it into frames. Each frame opens with a length header made of one or more octets. An octet of 255 adds 255 to a running total and says that the header continues. Any smaller octet adds its own value and closes the header. The resulting total is the count of payload bytes that follow. Short lengths therefore cost one octet, and any longer length costs one extra octet for every 255.

Once the header closes, the decoder reports the length with a one-cycle strobe. It then forwards exactly that many payload bytes downstream, unchanged, and tags the final one. The byte after that is decoded as the next header. A header whose total would not fit in the LEN_W-bit accumulator raises a one-cycle overflow strobe. That frame is then abandoned without any length report or payload.

Top module: `esc_len_decoder`

## Requirements
- R1: A header octet below 255 closes the header. On the clock edge that accepts it, len_valid goes high for exactly one cycle, and len_value carries the total of all octets of the header, each 255 octet counting 255.
- R2: A header octet equal to 255 adds 255 to the running total and keeps the decoder in the header. It produces no len_valid and no payload output.
- R3: If adding a header octet would push the total above 2^LEN_W-1, len_overflow pulses for one cycle after that octet is accepted. len_valid does not rise for that header and no payload is forwarded. Input octets up to and including the next octet below 255 are consumed and dropped, and the octet after that is decoded as a new header.
- R4: After a header of total N, exactly the next N accepted input bytes appear on out_data in order and unchanged, including bytes of value 255.
- R5: out_last is high together with out_valid on the N-th payload byte of a frame, and low on every other cycle.
- R6: A header of total 0 forwards no payload, and the very next input octet is decoded as a header.
- R7: While a header is being decoded, in_ready is high and out_valid is low.
- R8: While payload is being forwarded, in_ready equals out_ready and out_valid equals in_valid. A stall, or a gap on the input, loses and repeats no byte.
- R9: While rst_n is low, out_valid, len_valid and len_overflow are low. After reset the decoder reads the next octet as a header, even if reset struck in the middle of a payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Decoder accepts in_data this cycle |
| out_data | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | out_data holds a payload byte |
| out_ready | input | 1 | Downstream accepts out_data |
| out_last | output | 1 | Current payload byte ends the frame |
| len_value | output | LEN_W | Decoded payload length |
| len_valid | output | 1 | One-cycle strobe: len_value is new |
| len_overflow | output | 1 | One-cycle strobe: header total exceeded LEN_W bits |

## Verification
Frames are built from headers with zero, one, two, four and five escape octets, closed by terminators 0, 1, 3, 4, 5, 7 and 254. These cases separate the single-octet path from the escape chain. They also separate a length that ends exactly on a multiple of 255 from one that has a remainder. A total of exactly 2^LEN_W-1 is contrasted with overflow on the closing octet and with overflow on an escape octet. These show that the limit is inclusive and that the overflow path skips the rest of the broken header. Payloads are sent with stalls and input gaps and contain 255 bytes, which shows that the payload count and not the byte values ends a frame. A reset in the middle of a payload shows the return to header decoding.

// File: rtl/esc_len_pkg.sv
package esc_len_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PAY  = 2'd1,
        ST_SKIP = 2'd2
    } dec_state_e;

    localparam logic [7:0] ESC_OCTET = 8'hFF;
endpackage

// File: rtl/esc_len_accum.sv
module esc_len_accum #(
    parameter int LEN_W = 24
) (
    input  logic [LEN_W-1:0] total,
    input  logic [7:0]       octet,
    output logic [LEN_W-1:0] sum,
    output logic             carry,
    output logic             is_esc
);
    import esc_len_pkg::*;

    localparam int EXT_W = LEN_W + 1;

    logic [EXT_W-1:0] wide;

    always_comb begin
        wide   = {1'b0, total} + EXT_W'(octet);
        sum    = wide[LEN_W-1:0];
        carry  = wide[LEN_W];
        is_esc = (octet == ESC_OCTET);
    end
endmodule

// File: rtl/esc_len_pass.sv
module esc_len_pass (
    input  logic       pay_en,
    input  logic       last_hint,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       out_ready,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       beat
);
    always_comb begin
        out_valid = pay_en & in_valid;
        out_data  = in_data;
        in_ready  = pay_en ? out_ready : 1'b1;
        out_last  = out_valid & last_hint;
        beat      = out_valid & out_ready;
    end
endmodule

// File: rtl/esc_len_decoder.sv
module esc_len_decoder #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic [LEN_W-1:0] len_value,
    output logic             len_valid,
    output logic             len_overflow
);
    import esc_len_pkg::*;

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        dec_state_e       st;
        logic [LEN_W-1:0] total;
        logic [LEN_W-1:0] remain;
        logic [LEN_W-1:0] len;
        logic             len_vld;
        logic             ovf;
    } regs_t;

    regs_t r_d, r_q;

    logic [LEN_W-1:0] acc_sum;
    logic             acc_carry;
    logic             acc_esc;
    logic             beat;

    esc_len_accum #(.LEN_W(LEN_W)) u_accum (
        .total  (r_q.total),
        .octet  (in_data),
        .sum    (acc_sum),
        .carry  (acc_carry),
        .is_esc (acc_esc)
    );

    esc_len_pass u_pass (
        .pay_en    (r_q.st == ST_PAY),
        .last_hint (r_q.remain == ONE),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .beat      (beat)
    );

    always_comb begin
        r_d         = r_q;
        r_d.len_vld = 1'b0;
        r_d.ovf     = 1'b0;
        unique case (r_q.st)
            ST_HDR: begin
                if (in_valid) begin
                    if (acc_carry) begin
                        r_d.ovf   = 1'b1;
                        r_d.total = '0;
                        r_d.st    = acc_esc ? ST_SKIP : ST_HDR;
                    end else if (acc_esc) begin
                        r_d.total = acc_sum;
                    end else begin
                        r_d.total   = '0;
                        r_d.len     = acc_sum;
                        r_d.len_vld = 1'b1;
                        r_d.remain  = acc_sum;
                        r_d.st      = (acc_sum == '0) ? ST_HDR : ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                if (beat) begin
                    r_d.remain = r_q.remain - ONE;
                    if (r_q.remain == ONE) begin
                        r_d.st = ST_HDR;
                    end
                end
            end
            ST_SKIP: begin
                if (in_valid && !acc_esc) begin
                    r_d.st = ST_HDR;
                end
            end
            default: r_d.st = ST_HDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign len_value    = r_q.len;
    assign len_valid    = r_q.len_vld;
    assign len_overflow = r_q.ovf;
endmodule

// File: rtl/esc_len_checker.sv
module esc_len_checker #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       in_data,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [LEN_W-1:0] len_value,
    input logic             len_valid,
    input logic             len_overflow
);
    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] rem_eff;

    assign rem_eff = len_valid ? len_value : rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (out_valid && out_ready) begin
            rem_q <= rem_eff - LEN_W'(1);
        end else begin
            rem_q <= rem_eff;
        end
    end

    p_len_after_term_r1: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> $past(in_valid && in_ready && in_data != 8'hFF));

    p_ovf_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        len_overflow |-> $past(in_valid && in_ready));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(len_overflow && len_valid));

    p_pass_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_valid && out_data == in_data));

    p_last_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (rem_eff == LEN_W'(1)));

    p_no_beat_without_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rem_eff != '0));

    p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_ready_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready));

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (!len_valid && !len_overflow && !out_valid));
endmodule

bind esc_len_decoder esc_len_checker #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_data     (out_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_last     (out_last),
    .len_value    (len_value),
    .len_valid    (len_valid),
    .len_overflow (len_overflow)
);

// File: tb/esc_len_decoder_test.sv
`timescale 1ns/1ps
module esc_len_decoder_test;
    localparam int LW   = 10;
    localparam int LMAX = (1 << LW) - 1;
    localparam int NV   = 10;
    // per vector: escape count, closing octet, stalls/gaps in payload
    localparam int V_ESC [NV] = '{0, 0, 1, 1, 0,   2, 4, 4, 5, 0};
    localparam int V_TRM [NV] = '{5, 0, 0, 3, 254, 0, 3, 4, 7, 1};
    localparam int V_BP  [NV] = '{0, 0, 1, 0, 1,   0, 0, 0, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    out_data;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_last;
    logic [LW-1:0] len_value;
    logic          len_valid;
    logic          len_overflow;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic       s_lv, s_ov, s_ovalid, s_olast, s_irdy;
    logic [LW-1:0] s_lval;
    logic [7:0] s_odata;

    always #10 clk = ~clk;

    esc_len_decoder #(.LEN_W(LW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_last     (out_last),
        .len_value    (len_value),
        .len_valid    (len_valid),
        .len_overflow (len_overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // registered outputs are sampled before the new drive, combinational ones 1 ns after
    task automatic beat(input bit v, input logic [7:0] d, input bit r);
        @(negedge clk);
        s_lv   = len_valid;
        s_lval = len_value;
        s_ov   = len_overflow;
        in_valid  = v;
        in_data   = d;
        out_ready = r;
        #1;
        s_ovalid = out_valid;
        s_odata  = out_data;
        s_olast  = out_last;
        s_irdy   = in_ready;
    endtask

    task automatic send_frame(input int esc, input int trm, input bit bp);
        int  tot = 0;
        bit  ovf_seen = 0;
        bit  pend = 0;
        int  plen;
        for (int i = 0; i <= esc; i++) begin
            logic [7:0] oct = (i < esc) ? 8'hFF : 8'(trm);
            beat(1'b1, oct, 1'b1);
            chk(s_ov == pend, "R3", "len_overflow during header", s_ov, pend);
            chk(s_lv == 1'b0, "R2", "len_valid inside header", s_lv, 0);
            chk(s_irdy == 1'b1 && s_ovalid == 1'b0, "R7", "header ready/valid",
                {s_irdy, s_ovalid}, 2);
            pend = 0;
            if (!ovf_seen) begin
                tot += int'(oct);
                if (tot > LMAX) begin
                    ovf_seen = 1;
                    pend = 1;
                end
            end
        end
        plen = ovf_seen ? 0 : tot;
        if (plen == 0) begin
            beat(1'b0, 8'h00, 1'b1);
            chk(s_ov == pend, "R3", "overflow strobe", s_ov, pend);
            chk(s_lv == !ovf_seen, "R1", "len_valid after close", s_lv, !ovf_seen);
            if (!ovf_seen) chk(s_lval == 0, "R6", "zero length value", s_lval, 0);
            chk(s_ovalid == 1'b0, "R6", "no payload out", s_ovalid, 0);
        end else begin
            for (int k = 0; k < plen; k++) begin
                logic [7:0] d = 8'((plen * 7 + k * 13) ^ (k << 3));
                if (bp && (k % 3 == 1)) begin
                    beat(1'b1, d, 1'b0);
                    chk(s_ovalid == 1'b1 && s_irdy == 1'b0, "R8", "stall",
                        {s_ovalid, s_irdy}, 2);
                end
                if (bp && (k % 4 == 2)) begin
                    beat(1'b0, d, 1'b1);
                    chk(s_ovalid == 1'b0, "R8", "gap out_valid", s_ovalid, 0);
                end
                beat(1'b1, d, 1'b1);
                if (k == 0) begin
                    chk(s_lv == 1'b1, "R1", "len_valid strobe", s_lv, 1);
                    chk(int'(s_lval) == plen, "R1", "len_value", s_lval, plen);
                end
                chk(s_ovalid == 1'b1 && s_odata == d, "R4", "payload byte",
                    s_odata, d);
                chk(s_olast == (k == plen - 1), "R5", "out_last", s_olast,
                    (k == plen - 1));
            end
            beat(1'b0, 8'h00, 1'b1);
            chk(s_lv == 1'b0, "R1", "strobe one cycle only", s_lv, 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h05;
        #1;
        chk(len_valid == 0 && len_overflow == 0 && out_valid == 0, "R9",
            "outputs in reset", {len_valid, len_overflow, out_valid}, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            send_frame(V_ESC[v], V_TRM[v], V_BP[v] != 0);
        end

        // reset in the middle of a payload
        beat(1'b1, 8'd10, 1'b1);
        beat(1'b1, 8'hAA, 1'b1);
        beat(1'b1, 8'hBB, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        #1;
        chk(out_valid == 0 && in_ready == 1, "R9", "mid-payload reset",
            {out_valid, in_ready}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        send_frame(0, 2, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule